// File: doc/BRIEF.md
# Reset Cause and Watchdog Arm Register

This block is an 8-bit control and status register. It records why the system last left reset, and it holds the enable that lets the watchdog reset the chip. Four pulse inputs feed it: power-on reset, external reset, watchdog reset and a power-fail detection. Each of these inputs touches only the bits it owns. A power-on reset restores the whole register. An external reset preserves every bit. A watchdog reset marks its own flag and keeps the enable.

Software reads the register at any time on a combinational read port. It writes through a byte port with a one-cycle strobe. Writing a 0 to a flag bit clears that flag. Writing a 1 to a flag bit has no effect. The enable bit and the four spare bits are plain storage. The block also gates an incoming watchdog expiry with the enable bit, which yields the reset request passed to the reset generator.

All inputs are sampled on the rising clock edge. Each update appears on the read port one edge after its cause.

Top module: `rst_cause_reg`

## Requirements
- R1: An edge with `por` high loads the register with 0x40: bit 6 (power-on flag) is set, bit 4 (power-fail flag) is cleared, bit 2 (watchdog flag) is cleared, bit 1 (watchdog enable) is cleared, and spare bits 7, 5, 3 and 0 are cleared.
- R2: When `por` is high in the same cycle as any other reset, event or write, the result is still 0x40.
- R3: An edge with `wdt_rst` high sets bit 2 and leaves every other bit unchanged, including the enable in bit 1.
- R4: An edge with `ext_rst` high, and no other event, leaves all eight bits unchanged.
- R5: An edge with `pfail` high sets bit 4 and leaves every other bit unchanged.
- R6: A write with the strobe high clears each of flag bits 6, 4 and 2 whose data bit is 0. Each of those flags whose data bit is 1 is left unchanged.
- R7: A write loads bits 7, 5, 3, 1 and 0 with the written data.
- R8: A write whose strobe is high while `ext_rst` or `wdt_rst` is high is ignored.
- R9: When a flag's set event and a write clearing that flag fall on the same edge, the flag ends set.
- R10: `wdt_reset_req` is high exactly when `wdt_expire` is high and bit 1 is 1. It responds combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset pulse, highest priority |
| ext_rst | input | 1 | External reset pulse |
| wdt_rst | input | 1 | Watchdog-caused reset pulse |
| pfail | input | 1 | Power-fail detection event |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| wdt_expire | input | 1 | Watchdog counter expiry |
| wdt_reset_req | output | 1 | Expiry gated by the enable bit |

## Verification
Every bit is visible on `rd_data` one edge after its cause. A flag set or cleared by the wrong source, or a priority inverted between `por` and another input, therefore shows as a wrong byte at the very next read. An enable that is lost across a watchdog or external reset appears at once in two places: in bit 1 and in a missing `wdt_reset_req` when the next expiry comes. Set-versus-clear collisions are only visible on the edge where they coincide, so those cases are driven deliberately.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg (
  input  logic       clk,
  input  logic       por,
  input  logic       ext_rst,
  input  logic       wdt_rst,
  input  logic       pfail,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       wdt_expire,
  output logic       wdt_reset_req
);
  localparam logic [7:0] POR_VAL   = 8'h40;
  localparam logic [7:0] FLAG_MASK = 8'h54;
  localparam int         B_PF      = 4;
  localparam int         B_WDF     = 2;
  localparam int         B_EN      = 1;

  logic [7:0] q, wr_val, nxt;
  logic       wr_ok;

  assign wr_ok  = wr_en && !ext_rst && !wdt_rst;
  assign wr_val = (wr_data & ~FLAG_MASK) | (q & wr_data & FLAG_MASK);

  always_comb begin
    nxt = wr_ok ? wr_val : q;
    if (wdt_rst) nxt[B_WDF] = 1'b1;
    if (pfail)   nxt[B_PF]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (por) q <= POR_VAL;
    else     q <= nxt;
  end

  assign rd_data       = q;
  assign wdt_reset_req = wdt_expire & q[B_EN];

  p_por_value_r1: assert property (@(posedge clk) por |=> rd_data == 8'h40);
  p_por_wins_r2: assert property (@(posedge clk) (por && (wdt_rst || pfail)) |=> !rd_data[B_WDF] && !rd_data[B_PF]);
  p_wdt_flag_r3: assert property (@(posedge clk) disable iff (por) wdt_rst |=> rd_data[B_WDF]);
  p_en_keep_r3: assert property (@(posedge clk) disable iff (por) (wdt_rst || ext_rst) |=> rd_data[B_EN] == $past(rd_data[B_EN]));
  p_ext_hold_r4: assert property (@(posedge clk) disable iff (por) (ext_rst && !wdt_rst && !pfail) |=> $stable(rd_data));
  p_pf_flag_r5: assert property (@(posedge clk) disable iff (por) pfail |=> rd_data[B_PF]);
  p_req_gate_r10: assert property (@(posedge clk) wdt_reset_req |-> (rd_data[B_EN] && wdt_expire));
endmodule

// File: tb/rst_cause_reg_bench.sv
module rst_cause_reg_bench;
  logic clk = 1'b0;
  logic por = 1'b0, ext_rst = 1'b0, wdt_rst = 1'b0, pfail = 1'b0, wr_en = 1'b0, wdt_expire = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       wdt_reset_req;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #10 clk = ~clk;

  rst_cause_reg u_rst_cause_reg (
    .clk(clk), .por(por), .ext_rst(ext_rst), .wdt_rst(wdt_rst), .pfail(pfail),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .wdt_expire(wdt_expire), .wdt_reset_req(wdt_reset_req)
  );

  task automatic step(input logic p, input logic e, input logic w, input logic f,
                      input logic we, input logic [7:0] wd, input logic [7:0] exp, input string tag);
    @(negedge clk);
    por = p; ext_rst = e; wdt_rst = w; pfail = f; wr_en = we; wr_data = wd;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic check_req(input logic exp, input string tag);
    @(negedge clk);
    por = 0; ext_rst = 0; wdt_rst = 0; pfail = 0; wr_en = 0; wdt_expire = 1'b1;
    #1;
    checks++;
    if (wdt_reset_req !== exp) begin
      errors++;
      $display("FAIL %s wdt_reset_req actual %b expected %b", tag, wdt_reset_req, exp);
    end
    wdt_expire = 1'b0;
  endtask

  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      #5;
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s rd_data actual %h expected %h", t, rd_data, e);
      end
    end
  end

  initial begin
    step(1, 0, 0, 0, 0, 8'h00, 8'h40, "R1 reset value");
    step(0, 0, 0, 0, 0, 8'h00, 8'h40, "R1 hold after reset");
    step(0, 0, 0, 0, 1, 8'hAB, 8'hAB, "R6 R7 write clears flag, loads storage");
    step(0, 0, 1, 0, 0, 8'h00, 8'hAF, "R3 watchdog flag set, enable kept");
    step(0, 0, 0, 1, 0, 8'h00, 8'hBF, "R5 power-fail flag set");
    step(0, 1, 0, 0, 0, 8'h00, 8'hBF, "R4 external reset holds all");
    step(0, 1, 0, 0, 1, 8'h00, 8'hBF, "R8 write ignored under external reset");
    step(0, 0, 1, 0, 1, 8'h00, 8'hBF, "R8 write ignored under watchdog reset");
    step(0, 0, 0, 0, 1, 8'hFF, 8'hBF, "R6 writing ones leaves flags");
    step(0, 0, 0, 1, 1, 8'h02, 8'h12, "R9 set beats clear");
    check_req(1'b1, "R10 enabled expiry requests reset");
    step(0, 0, 0, 0, 1, 8'h00, 8'h00, "R6 R7 clear all");
    check_req(1'b0, "R10 disabled expiry blocked");
    step(1, 1, 1, 1, 1, 8'hFF, 8'h40, "R2 power-on priority");
    step(0, 0, 0, 0, 1, 8'hFF, 8'hEB, "R7 storage and enable writes");
    step(0, 0, 1, 1, 0, 8'h00, 8'hFF, "R3 R5 both flags set");
    check_req(1'b1, "R10 enable survives watchdog reset");
    step(0, 0, 0, 0, 0, 8'h00, 8'hFF, "R4 idle hold");
    @(negedge clk);
    por = 0; ext_rst = 0; wdt_rst = 0; pfail = 0; wr_en = 0;
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(20 * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog timeout actual hung expected finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule